// File: doc/BRIEF.md
# Flash Data-Polling Completion Checker

This block sits on the host side of a flash interface. It takes over once a program or erase command has been written to the device. After a start pulse it keeps reading one flash word and watches two status bits in the returned data. One is the completion bit, which copies the written data bit once the operation ends. The other is the failure flag. From these two bits it decides whether the embedded operation has finished, has failed, or is still running.

A failure flag that appears together with an unfinished completion bit does not end the operation at once. The two bits may change in the same cycle, so the engine reads the completion bit one more time before it decides. After a successful poll it reads the whole word once more and compares it with the intended value. A programmable poll budget bounds the loop.

The outcome is a single-cycle done pulse with a two-bit result code. The code stays on the output until the next accepted start. A reset-command request pulses alongside done whenever the device has to be returned to read mode.

Top module: `flash_poll_checker`

## Requirements
- R1: While `rst_n` is low and after its release, `busy_o`, `done_o`, `rd_valid_o` and `reset_req_o` are 0 and `result_o` is 0.
- R2: A read request holds `rd_valid_o` high and `rd_addr_o` stable until a cycle in which `rd_ready_i` is high. Only one read is outstanding at a time. A `start_i` that arrives while `busy_o` is high is ignored.
- R3: Status-poll reads (first polls and rechecks) use the latched address with bit 0 forced to 0. The final verify read uses the latched address unchanged.
- R4: With `hi_lane_i`=0 the completion bit is data bit 7 and the failure flag is bit 5. With `hi_lane_i`=1 they are bits 15 and 13.
- R5: In program mode (`erase_i`=0) a poll succeeds when the completion bit equals the same bit of `expect_i`. In erase mode (`erase_i`=1) a poll succeeds when the completion bit reads 1. A successful poll takes priority over the failure flag.
- R6: A poll that does not succeed and has the failure flag at 0 is followed by another poll read.
- R7: A poll that does not succeed with the failure flag at 1 is followed by exactly one recheck read. If that recheck succeeds, the engine moves on to the verify read. If it does not, the result is device error, code 1.
- R8: After a successful poll or recheck, one verify read compares all data bits with `expect_i` in program mode, or with all ones in erase mode. Equal gives pass, code 0. Unequal gives verify mismatch, code 2.
- R9: If the poll budget `max_polls_i` (a value of 0 counts as 1) of unsuccessful, flag-free poll reads is used up, the result is timeout, code 3. Recheck reads do not count against the budget.
- R10: `done_o` is high for exactly one cycle: the cycle after the read data that decides the outcome is accepted. `result_o` changes only with that pulse, or to 0 when a start is accepted, and is held otherwise.
- R11: `reset_req_o` pulses together with `done_o` exactly when the result is device error or timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a polling run (accepted when idle) |
| erase_i | input | 1 | 1 = erase operation, 0 = program operation |
| hi_lane_i | input | 1 | Select upper-byte status bits |
| addr_i | input | ADDR_W | Address of the word being checked |
| expect_i | input | DATA_W | Intended data word (program mode) |
| max_polls_i | input | CNT_W | Maximum number of clean unfinished polls |
| rd_valid_o | output | 1 | Read request valid |
| rd_ready_i | input | 1 | Read request accepted |
| rd_addr_o | output | ADDR_W | Read address |
| rd_data_valid_i | input | 1 | Read data returned |
| rd_data_i | input | DATA_W | Read data word |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | 0 pass, 1 device error, 2 verify mismatch, 3 timeout |
| reset_req_o | output | 1 | Request to issue a reset command to the flash |

## Verification
The properties assume that `rd_data_valid_i` pulses only once per accepted request. They also assume it never arrives in the same cycle as the acceptance, so each returned word belongs to the single outstanding read. The bench device model returns data one cycle after acceptance and raises `rd_ready_i` only while a request is pending, sometimes after several stall cycles. The properties also assume that `start_i` comes as a one-cycle pulse from an idle engine. The bench starts each run that way and only pulses `start_i` mid-run on purpose, to show that the pulse is ignored.

// File: rtl/flash_poll_pkg.sv
// Package: shared result codes and controller states for the polling checker.
// Assumes a two-bit result code is enough for the four outcomes.
package flash_poll_pkg;

    typedef enum logic [1:0] {
        RES_PASS       = 2'd0,
        RES_DEV_ERR    = 2'd1,
        RES_VERIFY_BAD = 2'd2,
        RES_TIMEOUT    = 2'd3
    } poll_result_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POLL_REQ,
        ST_POLL_WAIT,
        ST_RECK_REQ,
        ST_RECK_WAIT,
        ST_VER_REQ,
        ST_VER_WAIT
    } poll_state_e;

endpackage

// File: rtl/poll_bit_decode.sv
// Module: extracts the completion bit and failure flag from a returned word
// and decides whether the poll counts as finished.
// Assumes DATA_W is even and each byte lane holds at least six bits.
module poll_bit_decode #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] word_i,
    input  logic [DATA_W-1:0] expect_i,
    input  logic              hi_lane_i,
    input  logic              erase_i,
    output logic              poll_ok_o,
    output logic              fail_flag_o
);
    localparam int LANE_W  = DATA_W / 2;
    localparam int LO_POLL = LANE_W - 1;
    localparam int LO_FAIL = LANE_W - 3;
    localparam int HI_POLL = DATA_W - 1;
    localparam int HI_FAIL = DATA_W - 3;

    logic poll_bit;
    logic want_bit;

    // Pick the lane bits and compare against the bit expected at completion.
    always_comb begin
        poll_bit    = hi_lane_i ? word_i[HI_POLL]   : word_i[LO_POLL];
        fail_flag_o = hi_lane_i ? word_i[HI_FAIL]   : word_i[LO_FAIL];
        want_bit    = hi_lane_i ? expect_i[HI_POLL] : expect_i[LO_POLL];
        poll_ok_o   = erase_i ? poll_bit : (poll_bit == want_bit);
    end

endmodule

// File: rtl/poll_budget.sv
// Module: counts clean unfinished poll reads against a limit latched at start.
// Assumes the run ends no later than the read for which last_o is high.
module poll_budget #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic [CNT_W-1:0] limit_i,
    input  logic             step_i,
    output logic             last_o
);
    logic [CNT_W-1:0] used_q;
    logic [CNT_W-1:0] limit_q;

    // Reset the count and capture the limit on start; count each poll read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used_q  <= '0;
            limit_q <= '0;
        end else if (clear_i) begin
            used_q  <= '0;
            limit_q <= limit_i;
        end else if (step_i) begin
            used_q  <= used_q + 1'b1;
        end
    end

    // The current read is the final allowed one when it reaches the limit.
    always_comb begin
        last_o = ({1'b0, used_q} + 1'b1) >= {1'b0, limit_q};
    end

endmodule

// File: rtl/flash_poll_checker.sv
// Module: host-side engine that polls a flash word after a program or erase
// command, rechecks on a failure flag, verifies the final word, and reports
// a result code with a single-cycle done pulse.
// Assumes read data returns no earlier than the cycle after acceptance and
// exactly once per accepted request.
module flash_poll_checker
    import flash_poll_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 20,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              erase_i,
    input  logic              hi_lane_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] expect_i,
    input  logic [CNT_W-1:0]  max_polls_i,
    output logic              rd_valid_o,
    input  logic              rd_ready_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_data_valid_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [1:0]        result_o,
    output logic              reset_req_o
);
    poll_state_e       state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] expect_q;
    logic              erase_q;
    logic              hi_q;
    logic              done_q;
    logic              rst_req_q;
    poll_result_e      result_q;

    logic              accept;
    logic              finish;
    poll_result_e      finish_code;
    logic              step;
    logic              poll_ok;
    logic              fail_flag;
    logic              last_poll;
    logic [DATA_W-1:0] target_word;
    logic              verify_phase;

    poll_bit_decode #(.DATA_W(DATA_W)) u_decode (
        .word_i      (rd_data_i),
        .expect_i    (expect_q),
        .hi_lane_i   (hi_q),
        .erase_i     (erase_q),
        .poll_ok_o   (poll_ok),
        .fail_flag_o (fail_flag)
    );

    poll_budget #(.CNT_W(CNT_W)) u_budget (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (accept),
        .limit_i (max_polls_i),
        .step_i  (step),
        .last_o  (last_poll)
    );

    // Request and status outputs decoded from the controller state.
    always_comb begin
        accept       = (state_q == ST_IDLE) && start_i;
        verify_phase = (state_q == ST_VER_REQ);
        rd_valid_o   = (state_q == ST_POLL_REQ) || (state_q == ST_RECK_REQ)
                    || (state_q == ST_VER_REQ);
        rd_addr_o    = verify_phase ? addr_q : {addr_q[ADDR_W-1:1], 1'b0};
        busy_o       = (state_q != ST_IDLE);
        target_word  = erase_q ? {DATA_W{1'b1}} : expect_q;
        done_o       = done_q;
        result_o     = result_q;
        reset_req_o  = rst_req_q;
    end

    // Next-state logic: issue reads and judge each returned word.
    always_comb begin
        state_d     = state_q;
        finish      = 1'b0;
        finish_code = RES_PASS;
        step        = 1'b0;
        case (state_q)
            ST_IDLE:     if (start_i) state_d = ST_POLL_REQ;
            ST_POLL_REQ: if (rd_ready_i) state_d = ST_POLL_WAIT;
            ST_RECK_REQ: if (rd_ready_i) state_d = ST_RECK_WAIT;
            ST_VER_REQ:  if (rd_ready_i) state_d = ST_VER_WAIT;
            ST_POLL_WAIT: if (rd_data_valid_i) begin
                step = 1'b1;
                if (poll_ok) begin
                    state_d = ST_VER_REQ;
                end else if (fail_flag) begin
                    state_d = ST_RECK_REQ;
                end else if (last_poll) begin
                    finish      = 1'b1;
                    finish_code = RES_TIMEOUT;
                end else begin
                    state_d = ST_POLL_REQ;
                end
            end
            ST_RECK_WAIT: if (rd_data_valid_i) begin
                if (poll_ok) begin
                    state_d = ST_VER_REQ;
                end else begin
                    finish      = 1'b1;
                    finish_code = RES_DEV_ERR;
                end
            end
            ST_VER_WAIT: if (rd_data_valid_i) begin
                finish      = 1'b1;
                finish_code = (rd_data_i == target_word) ? RES_PASS : RES_VERIFY_BAD;
            end
            default: state_d = ST_IDLE;
        endcase
        if (finish) state_d = ST_IDLE;
    end

    // State register and operation parameters captured at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            addr_q   <= '0;
            expect_q <= '0;
            erase_q  <= 1'b0;
            hi_q     <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                addr_q   <= addr_i;
                expect_q <= expect_i;
                erase_q  <= erase_i;
                hi_q     <= hi_lane_i;
            end
        end
    end

    // Completion pulse, held result code and reset-command request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q    <= 1'b0;
            rst_req_q <= 1'b0;
            result_q  <= RES_PASS;
        end else begin
            done_q    <= finish;
            rst_req_q <= finish && ((finish_code == RES_DEV_ERR) || (finish_code == RES_TIMEOUT));
            if (finish) begin
                result_q <= finish_code;
            end else if (accept) begin
                result_q <= RES_PASS;
            end
        end
    end

endmodule

// File: rtl/flash_poll_sva.sv
// Module: property checker for the polling engine, bound to its top.
// Assumes the read handshake and start usage described in the brief.
module flash_poll_sva #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              rd_valid_o,
    input logic              rd_ready_i,
    input logic [ADDR_W-1:0] rd_addr_o,
    input logic              busy_o,
    input logic              done_o,
    input logic [1:0]        result_o,
    input logic              reset_req_o,
    input logic              verify_phase
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_addr_o)); // R2
    AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> busy_o); // R2
    AST_POLL_ADDR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o && !verify_phase |-> !rd_addr_o[0]); // R3
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R10
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R10
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_i && !busy_o) |=> done_o || $stable(result_o)); // R10
    AST_RESET_REQ_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req_o |-> done_o && (result_o == 2'd1 || result_o == 2'd3)); // R11
    AST_FAIL_HAS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && (result_o == 2'd1 || result_o == 2'd3) |-> reset_req_o); // R11
endmodule

bind flash_poll_checker flash_poll_sva #(.ADDR_W(ADDR_W)) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .rd_valid_o   (rd_valid_o),
    .rd_ready_i   (rd_ready_i),
    .rd_addr_o    (rd_addr_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .result_o     (result_o),
    .reset_req_o  (reset_req_o),
    .verify_phase (verify_phase)
);

// File: tb/flash_poll_checker_bench.sv
module flash_poll_checker_bench;
    localparam int DW = 16;
    localparam int AW = 20;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          erase_i = 1'b0;
    logic          hi_lane_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [DW-1:0] expect_i = '0;
    logic [CW-1:0] max_polls_i = '0;
    logic          rd_valid_o;
    logic          rd_ready_i = 1'b0;
    logic [AW-1:0] rd_addr_o;
    logic          rd_data_valid_i = 1'b0;
    logic [DW-1:0] rd_data_i = '0;
    logic          busy_o;
    logic          done_o;
    logic [1:0]    result_o;
    logic          reset_req_o;

    flash_poll_checker #(.DATA_W(DW), .ADDR_W(AW), .CNT_W(CW)) u_flash_poll_checker (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .erase_i(erase_i),
        .hi_lane_i(hi_lane_i), .addr_i(addr_i), .expect_i(expect_i),
        .max_polls_i(max_polls_i), .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i),
        .rd_addr_o(rd_addr_o), .rd_data_valid_i(rd_data_valid_i), .rd_data_i(rd_data_i),
        .busy_o(busy_o), .done_o(done_o), .result_o(result_o), .reset_req_o(reset_req_o)
    );

    always #4 clk = ~clk;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int last_dv_cyc = 0;
    int reads = 0;
    int stall = 0;
    int stall_left = 0;
    logic [DW-1:0] script [0:15];
    logic [AW-1:0] addr_log [0:15];
    int n_req = 0;

    // Result captured at the done pulse.
    logic [1:0] got_res;
    logic       got_rreq;
    int         got_lat;

    always @(posedge clk) cyc++;

    // Flash model: accepts a request after a stall, returns data the next cycle.
    always @(negedge clk) begin
        rd_data_valid_i = 1'b0;
        if (rd_ready_i) begin
            rd_ready_i      = 1'b0;
            rd_data_valid_i = 1'b1;
            rd_data_i       = script[reads];
            reads++;
            last_dv_cyc     = cyc;
        end else if (rd_valid_o) begin
            if (stall_left > 0) begin
                stall_left--;
            end else begin
                rd_ready_i = 1'b1;
                if (n_req < 16) addr_log[n_req] = rd_addr_o;
                n_req++;
                stall_left = stall;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Start one run and wait for its done pulse.
    task automatic run_op(input logic er, input logic hi, input logic [AW-1:0] a,
                          input logic [DW-1:0] ex, input logic [CW-1:0] mp);
        int waited;
        reads = 0; n_req = 0; stall_left = stall;
        @(negedge clk);
        erase_i = er; hi_lane_i = hi; addr_i = a; expect_i = ex; max_polls_i = mp;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        waited = 0;
        while (!done_o && waited < 2000) begin
            @(negedge clk);
            waited++;
        end
        if (!done_o) begin
            check(1'b0, "watchdog", waited, 0);
        end
        got_res  = result_o;
        got_rreq = reset_req_o;
        got_lat  = cyc - last_dv_cyc;
        @(negedge clk);
        check(!done_o, "R10 done single cycle", done_o, 0);
        check(result_o == got_res, "R10 result held", result_o, got_res);
    endtask

    task automatic t_reset;
        check(!busy_o && !done_o && !rd_valid_o && !reset_req_o, "R1 idle outputs",
              {busy_o, done_o, rd_valid_o, reset_req_o}, 0);
        check(result_o == 2'd0, "R1 result", result_o, 0);
    endtask

    task automatic t_prog_pass;
        script[0] = 16'h0000; script[1] = 16'h0000; script[2] = 16'h0080; script[3] = 16'hA5C3;
        run_op(1'b0, 1'b0, 20'h00100, 16'hA5C3, 16'd10);
        check(got_res == 2'd0, "R5 R6 R8 program pass", got_res, 0);
        check(reads == 4, "R6 poll count", reads, 4);
        check(got_rreq == 1'b0, "R11 no reset request", got_rreq, 0);
        check(got_lat == 1, "R10 done latency", got_lat, 1);
    endtask

    task automatic t_recheck_pass;
        script[0] = 16'h0020; script[1] = 16'h0080; script[2] = 16'hA5C3;
        run_op(1'b0, 1'b0, 20'h00100, 16'hA5C3, 16'd1);
        check(got_res == 2'd0, "R7 R9 recheck pass", got_res, 0);
        check(reads == 3, "R7 reads", reads, 3);
    endtask

    task automatic t_dev_err;
        script[0] = 16'h0020; script[1] = 16'h0020;
        run_op(1'b0, 1'b0, 20'h00100, 16'hA5C3, 16'd10);
        check(got_res == 2'd1, "R7 device error", got_res, 1);
        check(reads == 2, "R7 single recheck", reads, 2);
        check(got_rreq == 1'b1, "R11 reset on device error", got_rreq, 1);
    endtask

    task automatic t_erase_hi;
        script[0] = 16'h00A0; script[1] = 16'h8000; script[2] = 16'hFFFF;
        run_op(1'b1, 1'b1, 20'h00200, 16'h0000, 16'd10);
        check(got_res == 2'd0, "R4 R5 erase upper lane pass", got_res, 0);
        check(reads == 3, "R4 lower bits ignored", reads, 3);
    endtask

    task automatic t_erase_verify_bad;
        script[0] = 16'h8000; script[1] = 16'hFFFE;
        run_op(1'b1, 1'b1, 20'h00200, 16'hFFFE, 16'd10);
        check(got_res == 2'd2, "R8 erase verify mismatch", got_res, 2);
        check(got_rreq == 1'b0, "R11 no reset on mismatch", got_rreq, 0);
    endtask

    task automatic t_prog_hi_lane;
        script[0] = 16'h8080; script[1] = 16'h0080; script[2] = 16'h7F00;
        run_op(1'b0, 1'b1, 20'h00300, 16'h7F00, 16'd10);
        check(got_res == 2'd0, "R4 program upper lane", got_res, 0);
        check(reads == 3, "R4 upper poll bit used", reads, 3);
    endtask

    task automatic t_timeout;
        script[0] = 16'h0000; script[1] = 16'h0000; script[2] = 16'h0000; script[3] = 16'h0080;
        run_op(1'b0, 1'b0, 20'h00100, 16'hA5C3, 16'd3);
        check(got_res == 2'd3, "R9 timeout", got_res, 3);
        check(reads == 3, "R9 budget reads", reads, 3);
        check(got_rreq == 1'b1, "R11 reset on timeout", got_rreq, 1);
        run_op(1'b0, 1'b0, 20'h00100, 16'hA5C3, 16'd0);
        check(got_res == 2'd3 && reads == 1, "R9 zero budget", reads, 1);
    endtask

    task automatic t_addr_stall;
        stall = 3;
        script[0] = 16'h0000; script[1] = 16'h0080; script[2] = 16'hA5C3;
        run_op(1'b0, 1'b0, 20'h00013, 16'hA5C3, 16'd10);
        stall = 0;
        check(got_res == 2'd0 && reads == 3, "R2 stalled handshake", reads, 3);
        check(addr_log[0] == 20'h00012, "R3 poll address even", addr_log[0], 20'h00012);
        check(addr_log[1] == 20'h00012, "R3 second poll even", addr_log[1], 20'h00012);
        check(addr_log[2] == 20'h00013, "R3 verify address", addr_log[2], 20'h00013);
    endtask

    task automatic t_start_ignored;
        int waited;
        stall = 4;
        reads = 0; n_req = 0; stall_left = stall;
        script[0] = 16'h0080; script[1] = 16'hA5C3;
        @(negedge clk);
        erase_i = 1'b0; hi_lane_i = 1'b0; addr_i = 20'h00400; expect_i = 16'hA5C3;
        max_polls_i = 16'd10; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        erase_i = 1'b1; expect_i = 16'h0000; addr_i = 20'h00001; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        waited = 0;
        while (!done_o && waited < 2000) begin
            @(negedge clk);
            waited++;
        end
        stall = 0;
        check(done_o && result_o == 2'd0, "R2 start while busy ignored", result_o, 0);
        check(addr_log[1] == 20'h00400, "R2 address kept", addr_log[1], 20'h00400);
        @(negedge clk);
        repeat (3) @(negedge clk);
        check(!busy_o && reads == 2, "R2 no extra run", reads, 2);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_prog_pass();
        t_recheck_pass();
        t_dev_err();
        t_erase_hi();
        t_erase_verify_bad();
        t_prog_hi_lane();
        t_timeout();
        t_addr_stall();
        t_start_ignored();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Global watchdog.
    initial begin
        #800000;
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule